// File: doc/BRIEF.md
# Double-Buffered Simple SPI Engine

A byte-wide serial engine that acts as either the clock-driving controller (master) or the clocked responder (slave) on a four-wire SPI link. It exchanges 8-bit characters full-duplex. Every edge of the shared serial clock shifts one bit out and one bit in. The transmit side and the receive side each pair a one-entry holding buffer with a shift register. The user logic can therefore queue the next byte, or collect the last received byte, while a character is still on the wire. When the next byte is already queued at the end of a character, the master streams on without a pause.

Both byte interfaces are valid/ready streams. A transmit byte is taken on any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while the holding buffer is occupied, and the producer must hold `tx_data` steady until the byte is taken. A received byte is offered with `rx_valid` and stays unchanged until a cycle where `rx_ready` is high. Back-pressure on the receive side is lossy. A character that completes while the receive buffer is still full is discarded, and a sticky overrun flag is raised. The serial clock, select and data inputs pass through two-stage synchronizers. For this reason the master's half period (`cfg_div`+1 system clocks) should be at least 7 whenever the far end is a synchronized slave such as another instance of this block.

In master mode, the select input is ignored unless `cfg_sel_en` is set. When it is set, a low select signals that another master has taken the bus. The engine then releases its clock and data outputs and latches a mode fault. In slave mode, the engine reacts to the clock only while select is low, and it drives its data output only while select is low.

Top module: `spi_stream_engine`

## Requirements
- R1: After reset `sclk_o`=1, `tx_ready`=1, `rx_valid`=0, `busy`=0, `overrun`=0 and `mode_fault`=0. In master mode `sclk_oe`=1. In slave mode with `sel_n_i`=1, `miso_oe`=0.
- R2: In master mode the clock idles high, and each half period lasts `cfg_div`+1 system clocks. A character is 8 bits, sent MSB first. Output data changes only on a falling clock edge, and input data is sampled on the rising edge. A character therefore uses 8 falling and 8 rising edges and carries no parity bit.
- R3: Full duplex: in one character the master sends its queued byte to the slave, and the slave's queued byte arrives at the master.
- R4: The transmit holding buffer takes a new byte (`tx_ready`=1) as soon as the previous byte has moved into the shift register, which happens while that byte is still shifting.
- R5: If a byte is queued when a character ends, the master starts the next character at once. Consecutive falling clock edges stay exactly 2*(`cfg_div`+1) system clocks apart across character boundaries.
- R6: A received byte stays in the receive buffer, with `rx_valid`=1 and `rx_data` unchanged, until it is taken with `rx_ready`=1.
- R7: If a character completes while `rx_valid`=1 and `rx_ready`=0, `overrun` is set, the stored byte is kept, and the new byte is dropped.
- R8: When `cfg_invert`=1, queued transmit bytes are bit-inverted before shifting, and received bytes are bit-inverted before storing. If only one end inverts, the receiver gets the complement of the sent byte. If both ends invert, the byte arrives unchanged.
- R9: A slave ignores the serial clock while `sel_n_i`=1: no bit is counted and no byte is received. `miso_oe` equals the inverse of `sel_n_i` in slave mode.
- R10: A master with `cfg_sel_en`=0 ignores `sel_n_i` and never raises `mode_fault`.
- R11: A master with `cfg_sel_en`=1 whose synchronized `sel_n_i` is low sets `mode_fault`, and drops `sclk_oe` and `mosi_oe`. It keeps the clock idle high and starts no character until the fault is cleared. A byte queued during the fault is sent after the clear.
- R12: A slave whose transmit buffer is empty at the start of a character sends 8'hFF, and `cfg_invert` does not apply to it.
- R13: A `flag_clr` pulse clears `overrun` and `mode_fault`. A fault or overrun event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_sel_en | input | 1 | Master watches `sel_n_i` for a mode fault |
| cfg_invert | input | 1 | Invert transmitted and received data bits |
| cfg_div | input | DIV_W | Master half period minus one, in system clocks |
| flag_clr | input | 1 | Clear `overrun` and `mode_fault` |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding buffer empty |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| sclk_i | input | 1 | Serial clock in (slave) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| mosi_i | input | 1 | Controller-out data in (slave) |
| mosi_o | output | 1 | Controller-out data out (master) |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Responder-out data in (master) |
| miso_o | output | 1 | Responder-out data out (slave) |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| sel_n_i | input | 1 | Active-low select input |
| busy | output | 1 | Character in progress |
| overrun | output | 1 | Sticky receive overrun flag |
| mode_fault | output | 1 | Sticky master mode-fault flag |

## Verification
The bench builds two instances with the default `DIV_W`=8. One is wired as master and one as slave, back to back, with half periods of 8, 9 and 12 system clocks (`cfg_div` 7, 8, 11). These rates clear the synchronizer latency and still keep an exhaustive sweep short. The sweep streams all 256 byte values in both directions at once. This exposes every bit pattern and every character boundary to the gap and edge-count checks, and it also covers inversion at one end and at both ends. Directed sequences then cover the underrun byte, overrun with the held byte kept, clock masking while the slave is deselected, and both settings of the select-enable control.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W);

  typedef struct packed {
    logic fall;
    logic rise;
  } spi_edge_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_master_clk.sv
module spi_master_clk
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pending,
  input  logic             last,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             active,
  output spi_edge_t        edges
);
  logic [DIV_W-1:0] cnt;
  logic             terminal;

  always_comb begin
    terminal   = active && (cnt == div);
    edges.fall = en && ((!active && pending) || (terminal && sclk));
    edges.rise = en && terminal && !sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk   <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
    end else if (!en) begin
      sclk   <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (pending) begin
        active <= 1'b1;
        sclk   <= 1'b0;
        cnt    <= '0;
      end
    end else if (terminal) begin
      cnt  <= '0;
      sclk <= !sclk;
      if (!sclk && last && !pending) active <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_slave_edges.sv
module spi_slave_edges
  import spi_eng_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      sel_act,
  output spi_edge_t edges
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= sclk_s;
  end

  always_comb begin
    edges.fall = sel_act && prev && !sclk_s;
    edges.rise = sel_act && !prev && sclk_s;
  end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              fall,
  input  logic              first,
  input  logic              invert,
  output logic              pending,
  output logic              sdo
);
  logic [CHAR_W-1:0] hold;
  logic [CHAR_W-1:0] shreg;
  logic              load;

  assign tx_ready = !pending;
  assign load     = fall && first;
  assign sdo      = shreg[CHAR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      pending <= 1'b0;
    end else if (tx_valid && !pending) begin
      hold    <= tx_data;
      pending <= 1'b1;
    end else if (load) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
    end else if (load) begin
      shreg <= pending ? (hold ^ {CHAR_W{invert}}) : '1;
    end else if (fall) begin
      shreg <= {shreg[CHAR_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              last,
  input  logic              din,
  input  logic              invert,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ovr_evt
);
  logic [CHAR_W-1:0] shreg;
  logic [CHAR_W-1:0] word;
  logic              done;
  logic              pop;

  always_comb begin
    word    = {shreg[CHAR_W-2:0], din} ^ {CHAR_W{invert}};
    done    = rise && last;
    pop     = rx_valid && rx_ready;
    ovr_evt = done && rx_valid && !rx_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (rise) shreg <= {shreg[CHAR_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (done && !ovr_evt) begin
      rx_data  <= word;
      rx_valid <= 1'b1;
    end else if (pop) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_stream_engine.sv
module spi_stream_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_sel_en,
  input  logic              cfg_invert,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              flag_clr,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              sel_n_i,
  output logic              busy,
  output logic              overrun,
  output logic              mode_fault
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] raw_in, syn_in;
  logic              sclk_s, sel_s, din_s;
  logic              fault_now, clk_en, sel_act, abort;
  logic              m_sclk, m_active;
  spi_edge_t         m_edges, s_edges, edges;
  logic [CNT_W-1:0]  bit_cnt;
  logic              first, last;
  logic              pending, sdo, ovr_evt;

  assign raw_in = {sclk_i, sel_n_i, cfg_master ? miso_i : mosi_i};
  assign {sclk_s, sel_s, din_s} = syn_in;

  spi_in_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  always_comb begin
    fault_now = cfg_master && cfg_sel_en && !sel_s;
    clk_en    = cfg_master && !mode_fault && !fault_now;
    sel_act   = !cfg_master && !sel_s;
    edges     = cfg_master ? m_edges : s_edges;
    abort     = cfg_master ? !clk_en : !sel_act;
    first     = (bit_cnt == '0);
    last      = (bit_cnt == CNT_W'(CHAR_W - 1));
  end

  spi_master_clk #(.DIV_W(DIV_W)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .pending(pending), .last(last),
    .div(cfg_div), .sclk(m_sclk), .active(m_active), .edges(m_edges)
  );

  spi_slave_edges u_sedge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sel_act(sel_act), .edges(s_edges)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bit_cnt <= '0;
    else if (abort)      bit_cnt <= '0;
    else if (edges.rise) bit_cnt <= last ? '0 : bit_cnt + 1'b1;
  end

  spi_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .fall(edges.fall), .first(first), .invert(cfg_invert),
    .pending(pending), .sdo(sdo)
  );

  spi_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .rise(edges.rise), .last(last), .din(din_s),
    .invert(cfg_invert), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .ovr_evt(ovr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun    <= 1'b0;
      mode_fault <= 1'b0;
    end else begin
      if (ovr_evt)       overrun <= 1'b1;
      else if (flag_clr) overrun <= 1'b0;
      if (fault_now)     mode_fault <= 1'b1;
      else if (flag_clr) mode_fault <= 1'b0;
    end
  end

  always_comb begin
    sclk_o  = m_sclk;
    sclk_oe = cfg_master && !mode_fault;
    mosi_o  = sdo;
    mosi_oe = cfg_master && !mode_fault;
    miso_o  = sdo;
    miso_oe = !cfg_master && !sel_n_i;
    busy    = cfg_master ? m_active : (sel_act && !first);
  end
endmodule

// File: rtl/spi_stream_engine_chk.sv
module spi_stream_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       sel_n_i,
  input logic       busy,
  input logic       overrun,
  input logic       mode_fault
);
  a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(mosi_o)) |-> $fell(sclk_o));

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(!busy) && !busy) |-> sclk_o);

  a_r4_hold_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r7_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (rx_valid && $stable(rx_data)));

  a_r9_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2)
     && $past(sel_n_i, 3) && $past(sel_n_i, 4)) |-> !$rose(rx_valid));

  a_r11_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && mode_fault && $past(mode_fault)) |-> (sclk_o && !busy));
endmodule

bind spi_stream_engine spi_stream_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .sclk_o(sclk_o), .mosi_o(mosi_o), .sel_n_i(sel_n_i),
  .busy(busy), .overrun(overrun), .mode_fault(mode_fault)
);

// File: tb/tb_spi_stream_engine.sv
`timescale 1ns/1ps
module tb_spi_stream_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // master side
  logic       m_sel_en = 0, m_inv = 0, m_clr = 0, m_sel_n = 1;
  logic [7:0] m_div = 8'd7;
  logic [7:0] m_txd = 0;
  logic       m_txv = 0;
  wire        m_txr, m_rxv, m_sclk_o, m_sclk_oe, m_mosi_o, m_mosi_oe;
  wire        m_miso_o, m_miso_oe, m_busy, m_ovr, m_fault;
  wire [7:0]  m_rxd;
  // slave side
  logic       s_inv = 0, s_clr = 0, s_sel_n = 1, s_rxr = 1;
  logic [7:0] s_txd = 0;
  logic       s_txv = 0;
  wire        s_txr, s_rxv, s_sclk_o, s_sclk_oe, s_mosi_o, s_mosi_oe;
  wire        s_miso_o, s_miso_oe, s_busy, s_ovr, s_fault;
  wire [7:0]  s_rxd;

  wire sclk_line = m_sclk_oe ? m_sclk_o : 1'b1;
  wire mosi_line = m_mosi_oe ? m_mosi_o : 1'b1;
  wire miso_line = s_miso_oe ? s_miso_o : 1'b1;

  spi_stream_engine #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b1), .cfg_sel_en(m_sel_en),
    .cfg_invert(m_inv), .cfg_div(m_div), .flag_clr(m_clr),
    .tx_data(m_txd), .tx_valid(m_txv), .tx_ready(m_txr),
    .rx_data(m_rxd), .rx_valid(m_rxv), .rx_ready(1'b1),
    .sclk_i(1'b1), .sclk_o(m_sclk_o), .sclk_oe(m_sclk_oe),
    .mosi_i(1'b1), .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe),
    .miso_i(miso_line), .miso_o(m_miso_o), .miso_oe(m_miso_oe),
    .sel_n_i(m_sel_n), .busy(m_busy), .overrun(m_ovr), .mode_fault(m_fault)
  );

  spi_stream_engine #(.DIV_W(8)) peer (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_sel_en(1'b0),
    .cfg_invert(s_inv), .cfg_div(8'd0), .flag_clr(s_clr),
    .tx_data(s_txd), .tx_valid(s_txv), .tx_ready(s_txr),
    .rx_data(s_rxd), .rx_valid(s_rxv), .rx_ready(s_rxr),
    .sclk_i(sclk_line), .sclk_o(s_sclk_o), .sclk_oe(s_sclk_oe),
    .mosi_i(mosi_line), .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe),
    .miso_i(1'b1), .miso_o(s_miso_o), .miso_oe(s_miso_oe),
    .sel_n_i(s_sel_n), .busy(s_busy), .overrun(s_ovr), .mode_fault(s_fault)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // clock-gap monitor on the master's serial clock
  int  cyc = 0, last_fall = 0, falls = 0, gap_bad = 0;
  bit  have_prev = 0, gap_en = 0;
  logic prev_sclk = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (gap_en && prev_sclk && !m_sclk_o) begin
      if (have_prev && (cyc - last_fall) != 2 * (int'(m_div) + 1)) gap_bad++;
      have_prev = 1;
      last_fall = cyc;
      falls++;
    end
    prev_sclk = m_sclk_o;
  end

  task automatic push_m(input logic [7:0] d);
    @(negedge clk);
    m_txd = d; m_txv = 1;
    while (!m_txr) @(negedge clk);
    @(negedge clk);
    m_txv = 0;
  endtask

  task automatic push_s(input logic [7:0] d);
    @(negedge clk);
    s_txd = d; s_txv = 1;
    while (!s_txr) @(negedge clk);
    @(negedge clk);
    s_txv = 0;
  endtask

  task automatic get_m(output logic [7:0] d);
    @(negedge clk);
    while (!m_rxv) @(negedge clk);
    d = m_rxd;
  endtask

  task automatic get_s(output logic [7:0] d);
    @(negedge clk);
    while (!(s_rxv && s_rxr)) @(negedge clk);
    d = s_rxd;
  endtask

  function automatic logic [7:0] s_byte(int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic stream(int n, int base, logic [7:0] div, logic mi, logic si);
    logic [7:0] flip;
    flip = (mi ^ si) ? 8'hFF : 8'h00;
    m_div = div; m_inv = mi; s_inv = si;
    have_prev = 0; falls = 0; gap_bad = 0; gap_en = 1;
    fork
      for (int i = 0; i < n; i++) push_m(8'(base + i));
      for (int i = 0; i < n; i++) push_s(s_byte(base + i));
      for (int i = 0; i < n; i++) begin
        logic [7:0] r;
        get_m(r);
        check("R3", r, s_byte(base + i) ^ flip, "master rx byte");
      end
      for (int i = 0; i < n; i++) begin
        logic [7:0] r;
        get_s(r);
        check((mi ^ si) ? "R8" : "R3", r, 8'(base + i) ^ flip, "slave rx byte");
      end
    join
    gap_en = 0;
    check("R5", gap_bad, 0, "irregular clock gaps");
    check("R2", falls, 8 * n, "falling edges per stream");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rm, rs;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // R1 reset state
    check("R1", m_sclk_o, 1, "sclk idle");
    check("R1", m_tx_ready_chk(), 1, "tx_ready");
    check("R1", m_rxv, 0, "rx_valid");
    check("R1", m_busy, 0, "busy");
    check("R1", {m_ovr, m_fault}, 0, "flags");
    check("R1", m_sclk_oe, 1, "master sclk_oe");
    check("R1", s_miso_oe, 0, "slave miso_oe deselected");

    s_sel_n = 0;
    wait_cyc(1);
    check("R9", s_miso_oe, 1, "slave miso_oe selected");
    wait_cyc(4);

    // exhaustive sweep, then inversion at one and both ends
    stream(256, 0, 8'd7, 0, 0);
    wait_cyc(20);
    stream(64, 100, 8'd11, 1, 0);
    wait_cyc(20);
    stream(16, 200, 8'd8, 1, 1);
    wait_cyc(20);
    m_inv = 0; s_inv = 0; m_div = 8'd7;

    // R12 slave underrun
    fork push_m(8'h3C); get_m(rm); get_s(rs); join
    check("R12", rm, 8'hFF, "underrun byte at master");
    check("R3", rs, 8'h3C, "slave rx during underrun");
    s_inv = 1;
    fork push_m(8'h3C); get_m(rm); get_s(rs); join
    check("R12", rm, 8'hFF, "underrun byte not inverted");
    s_inv = 0;
    wait_cyc(10);

    // R7 overrun
    s_rxr = 0;
    fork
      begin push_m(8'hA1); push_m(8'hB2); end
      begin get_m(rm); get_m(rm); end
    join
    wait_cyc(20);
    check("R7", s_ovr, 1, "overrun flag");
    check("R6", s_rxv, 1, "held byte still valid");
    check("R7", s_rxd, 8'hA1, "first byte kept");
    s_rxr = 1;
    wait_cyc(1);
    s_rxr = 0;
    check("R7", s_rxv, 0, "second byte dropped");
    s_clr = 1; wait_cyc(1); s_clr = 0;
    check("R13", s_ovr, 0, "overrun cleared");
    s_rxr = 1;
    wait_cyc(5);

    // R9 deselected slave ignores the clock
    s_sel_n = 1;
    wait_cyc(1);
    check("R9", s_miso_oe, 0, "miso released");
    fork push_m(8'h77); get_m(rm); join
    wait_cyc(12);
    check("R9", s_rxv, 0, "no byte while deselected");
    s_sel_n = 0;
    wait_cyc(4);
    fork push_s(8'hC3); push_m(8'h5E); get_m(rm); get_s(rs); join
    check("R9", rs, 8'h5E, "clean byte after reselect");
    check("R3", rm, 8'hC3, "master gets slave byte");
    wait_cyc(5);

    // R10 select ignored when select-enable is clear
    m_sel_n = 0;
    fork push_m(8'h11); get_m(rm); get_s(rs); join
    check("R10", rs, 8'h11, "transfer with select low");
    check("R10", m_fault, 0, "no mode fault");
    m_sel_n = 1;
    wait_cyc(5);

    // R11 mode fault
    m_sel_en = 1; m_sel_n = 0;
    wait_cyc(4);
    check("R11", m_fault, 1, "mode fault set");
    check("R11", {m_sclk_oe, m_mosi_oe}, 0, "outputs released");
    push_m(8'h99);
    wait_cyc(40);
    check("R11", m_busy, 0, "no transfer during fault");
    check("R11", m_sclk_o, 1, "clock idle during fault");
    check("R11", s_rxv, 0, "slave saw nothing");
    m_sel_n = 1;
    wait_cyc(4);
    m_clr = 1; wait_cyc(1); m_clr = 0;
    check("R13", m_fault, 0, "fault cleared");
    check("R11", m_sclk_oe, 1, "clock driven again");
    fork get_m(rm); get_s(rs); join
    check("R11", rs, 8'h99, "queued byte sent after clear");
    m_sel_en = 0;
    wait_cyc(10);
    finish_run();
  end

  function automatic logic m_tx_ready_chk();
    return m_txr;
  endfunction
endmodule